// File: doc/BRIEF.md
# Register-Mapped Serial Port with Split Interrupts

This block is a small asynchronous serial port that sits on a plain synchronous register bus. Software writes one character at a time into a single transmit holding register and reads received characters from a single receive holding register. Frames are always one start bit, eight data bits sent least significant bit first, and one stop bit, with no parity. The bit period in clock cycles is set directly by a divisor register, with no fixed oversampling ratio.

Events are latched in an interrupt flag register that software clears by writing ones. Three interrupt outputs are provided: one for transmit, one for receive, and one that merges transmit overrun and receive overrun so it can be shared. A driver normally polls the status register or waits on an interrupt, writes the next character only while the transmit holding register is free, and reads a character whenever the receive holding register is full.

Top module: `uart_mm`

## Requirements
- R1: After reset, status (0x04), control (0x08) and interrupt flags (0x0C) read 0, the divisor (0x10) reads 16, the serial output is high and all three interrupt outputs are low.
- R2: With control bit 0 set, a held character is sent as a low start bit, 8 data bits LSB first and a high stop bit, each bit lasting the effective divisor in clock cycles; the line is high when idle and nothing is sent while control bit 0 is clear.
- R3: A write to offset 0x00 while status bit 0 is clear stores the byte and sets status bit 0; when the byte moves into the idle shifter, status bit 0 clears and interrupt flag bit 0 sets.
- R4: A write to offset 0x00 while status bit 0 is set drops the byte and sets status bit 2 and interrupt flag bit 2; the held byte is still the one sent.
- R5: With control bit 1 set, an incoming frame is sampled at the middle of each bit; a good character arriving while status bit 1 is clear is stored, sets status bit 1 and interrupt flag bit 1; a read of offset 0x00 returns it and clears status bit 1.
- R6: A good character arriving while status bit 1 is set is discarded and sets status bit 3 and interrupt flag bit 3; the stored character is kept.
- R7: A character whose stop bit samples low is discarded without changing status or flags.
- R8: With control bit 1 clear, activity on the serial input has no effect.
- R9: Writing ones to interrupt flag bits 3:0 clears those bits only; writing ones to status bits 2 and 3 clears those sticky overrun bits.
- R10: Transmit interrupt is flag bit 0 AND control bit 2; receive interrupt is flag bit 1 AND control bit 3; the overrun interrupt is (flag bit 2 AND control bit 4) OR (flag bit 3 AND control bit 5).
- R11: The divisor register holds 21 bits at offset 0x10; values below 16 act as 16.
- R12: Control bits 5:0 at offset 0x08 are written and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Register byte offset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (pops receive data) |
| wdata_i | input | DIV_W | Write data |
| rdata_o | output | DIV_W | Read data, combinational from addr_i |
| txd_o | output | 1 | Serial output |
| rxd_i | input | 1 | Serial input |
| tx_irq_o | output | 1 | Transmit interrupt |
| rx_irq_o | output | 1 | Receive interrupt |
| ovr_irq_o | output | 1 | Combined overrun interrupt |

## Verification
A stuck holding-register full flag shows at once on the status read and, within one frame, as a missing or repeated character on the serial output. A wrong bit counter or divisor path shows as a misplaced or corrupted bit within the first frame, and the bench measures the exact number of low cycles of an all-zero frame to expose a one-cycle error in bit length. Flag and mask mix-ups appear on the interrupt pins in the cycle after the event, and overrun or framing mistakes surface as a changed stored character on the next data read.

// File: rtl/uart_mm_pkg.sv
package uart_mm_pkg;
  localparam logic [4:0] OFF_DATA  = 5'h00;
  localparam logic [4:0] OFF_STATE = 5'h04;
  localparam logic [4:0] OFF_CTRL  = 5'h08;
  localparam logic [4:0] OFF_INT   = 5'h0C;
  localparam logic [4:0] OFF_BAUD  = 5'h10;

  localparam int C_TX_EN   = 0;
  localparam int C_RX_EN   = 1;
  localparam int C_TX_IE   = 2;
  localparam int C_RX_IE   = 3;
  localparam int C_TXO_IE  = 4;
  localparam int C_RXO_IE  = 5;

  localparam int DIV_MIN    = 16;
  localparam int FRAME_BITS = 10;
  localparam int DATA_BITS  = 8;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/uart_mm_tx.sv
module uart_mm_tx import uart_mm_pkg::*; #(
  parameter int DIV_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [7:0]       data_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             busy_o,
  output logic             txd_o
);
  localparam int BC_W = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sh_q;
  logic [BC_W-1:0]       bit_q;
  logic [DIV_W-1:0]      tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      bit_q  <= '0;
      tick_q <= '0;
      busy_o <= 1'b0;
    end else if (!busy_o) begin
      if (start_i) begin
        sh_q   <= {1'b1, data_i, 1'b0};
        bit_q  <= '0;
        tick_q <= div_i - 1'b1;
        busy_o <= 1'b1;
      end
    end else if (tick_q == '0) begin
      if (bit_q == BC_W'(FRAME_BITS - 1)) begin
        busy_o <= 1'b0;
      end else begin
        sh_q   <= {1'b1, sh_q[FRAME_BITS-1:1]};
        bit_q  <= bit_q + 1'b1;
        tick_q <= div_i - 1'b1;
      end
    end else begin
      tick_q <= tick_q - 1'b1;
    end
  end

  assign txd_o = sh_q[0];

  p_idle_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> txd_o);
  p_start_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && !txd_o));
endmodule

// File: rtl/uart_mm_rx.sv
module uart_mm_rx import uart_mm_pkg::*; #(
  parameter int DIV_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rxd_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             valid_o,
  output logic [7:0]       data_o
);
  localparam int BC_W = $clog2(DATA_BITS);

  rx_state_e        st_q;
  logic [1:0]       sync_q;
  logic [DIV_W-1:0] tick_q;
  logic [BC_W-1:0]  bit_q;
  logic [7:0]       sh_q;
  logic             rxd_s;

  assign rxd_s = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 2'b11;
      st_q    <= RX_IDLE;
      tick_q  <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      sync_q  <= {sync_q[0], rxd_i};
      valid_o <= 1'b0;
      if (!en_i) begin
        st_q <= RX_IDLE;
      end else begin
        unique case (st_q)
          RX_IDLE: if (!rxd_s) begin
            st_q   <= RX_START;
            tick_q <= (div_i >> 1) - 1'b1;
          end
          RX_START: if (tick_q == '0) begin
            st_q   <= rxd_s ? RX_IDLE : RX_DATA;
            tick_q <= div_i - 1'b1;
            bit_q  <= '0;
          end else tick_q <= tick_q - 1'b1;
          RX_DATA: if (tick_q == '0) begin
            sh_q   <= {rxd_s, sh_q[7:1]};
            tick_q <= div_i - 1'b1;
            if (bit_q == BC_W'(DATA_BITS - 1)) st_q <= RX_STOP;
            else bit_q <= bit_q + 1'b1;
          end else tick_q <= tick_q - 1'b1;
          RX_STOP: if (tick_q == '0) begin
            valid_o <= rxd_s;  // low stop bit: framing error, drop
            data_o  <= sh_q;
            st_q    <= RX_IDLE;
          end else tick_q <= tick_q - 1'b1;
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  p_valid_from_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($past(st_q) == RX_STOP && $past(rxd_s)));
  p_disabled_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !valid_o);
endmodule

// File: rtl/uart_mm.sv
module uart_mm import uart_mm_pkg::*; #(
  parameter int DIV_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [4:0]       addr_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [DIV_W-1:0] wdata_i,
  output logic [DIV_W-1:0] rdata_o,
  output logic             txd_o,
  input  logic             rxd_i,
  output logic             tx_irq_o,
  output logic             rx_irq_o,
  output logic             ovr_irq_o
);
  logic [5:0]       ctrl_q;
  logic [3:0]       int_q;
  logic [DIV_W-1:0] baud_q, eff_div;
  logic [7:0]       tx_buf_q, rx_buf_q, rx_data;
  logic             tx_full_q, rx_full_q, tx_ovr_q, rx_ovr_q;
  logic             tx_busy, tx_load, rx_valid, rx_take;
  logic             wr_data, wr_state, wr_ctrl, wr_int, wr_baud, rd_data;
  logic             tx_ovr_ev, rx_ovr_ev;

  assign wr_data  = wr_en_i && addr_i == OFF_DATA;
  assign wr_state = wr_en_i && addr_i == OFF_STATE;
  assign wr_ctrl  = wr_en_i && addr_i == OFF_CTRL;
  assign wr_int   = wr_en_i && addr_i == OFF_INT;
  assign wr_baud  = wr_en_i && addr_i == OFF_BAUD;
  assign rd_data  = rd_en_i && addr_i == OFF_DATA;

  assign eff_div   = (baud_q < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : baud_q;
  assign tx_load   = tx_full_q && ctrl_q[C_TX_EN] && !tx_busy;
  assign tx_ovr_ev = wr_data && tx_full_q;
  assign rx_take   = rx_valid && !rx_full_q;
  assign rx_ovr_ev = rx_valid && rx_full_q;

  uart_mm_tx #(.DIV_W(DIV_W)) u_tx (
    .clk_i, .rst_ni, .start_i(tx_load), .data_i(tx_buf_q), .div_i(eff_div),
    .busy_o(tx_busy), .txd_o
  );

  uart_mm_rx #(.DIV_W(DIV_W)) u_rx (
    .clk_i, .rst_ni, .en_i(ctrl_q[C_RX_EN]), .rxd_i, .div_i(eff_div),
    .valid_o(rx_valid), .data_o(rx_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      int_q     <= '0;
      baud_q    <= DIV_W'(DIV_MIN);
      tx_buf_q  <= '0;
      rx_buf_q  <= '0;
      tx_full_q <= 1'b0;
      rx_full_q <= 1'b0;
      tx_ovr_q  <= 1'b0;
      rx_ovr_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i[5:0];
      if (wr_baud) baud_q <= wdata_i;

      if (wr_data && !tx_full_q) begin
        tx_buf_q  <= wdata_i[7:0];
        tx_full_q <= 1'b1;
      end else if (tx_load) begin
        tx_full_q <= 1'b0;
      end

      if (rx_take) begin
        rx_buf_q  <= rx_data;
        rx_full_q <= 1'b1;
      end else if (rd_data) begin
        rx_full_q <= 1'b0;
      end

      tx_ovr_q <= (tx_ovr_q && !(wr_state && wdata_i[2])) || tx_ovr_ev;
      rx_ovr_q <= (rx_ovr_q && !(wr_state && wdata_i[3])) || rx_ovr_ev;
      // new events win over a same-cycle clear
      int_q <= (int_q & ~({4{wr_int}} & wdata_i[3:0]))
             | {rx_ovr_ev, tx_ovr_ev, rx_take, tx_load};
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_DATA:  rdata_o[7:0] = rx_buf_q;
      OFF_STATE: rdata_o[3:0] = {rx_ovr_q, tx_ovr_q, rx_full_q, tx_full_q};
      OFF_CTRL:  rdata_o[5:0] = ctrl_q;
      OFF_INT:   rdata_o[3:0] = int_q;
      OFF_BAUD:  rdata_o      = baud_q;
      default:   rdata_o      = '0;
    endcase
  end

  assign tx_irq_o  = int_q[0] && ctrl_q[C_TX_IE];
  assign rx_irq_o  = int_q[1] && ctrl_q[C_RX_IE];
  assign ovr_irq_o = (int_q[2] && ctrl_q[C_TXO_IE]) || (int_q[3] && ctrl_q[C_RXO_IE]);

  p_load_frees_buf_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load |=> (!tx_full_q && int_q[0] && tx_busy));
  p_tx_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && tx_full_q && !tx_load) |=> ($stable(tx_buf_q) && tx_ovr_q && int_q[2]));
  p_rx_accept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_take |=> (rx_full_q && int_q[1]));
  p_rx_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ovr_ev |=> ($stable(rx_buf_q) && rx_ovr_q && int_q[3]));
  p_no_tx_when_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[C_TX_EN] |-> !tx_load);
endmodule

// File: tb/uart_mm_bench.sv
`timescale 1ns/1ps
module uart_mm_bench;
  localparam int DIV_W = 21;
  localparam logic [4:0] A_DATA = 5'h00, A_STATE = 5'h04, A_CTRL = 5'h08,
                         A_INT = 5'h0C, A_BAUD = 5'h10;
  // {direction (0 = transmit, 1 = receive), byte}
  localparam logic [8:0] VEC [6] = '{9'h0A5, 9'h001, 9'h080, 9'h13C, 9'h1FF, 9'h100};

  logic             clk_i = 1'b0, rst_ni = 1'b0;
  logic [4:0]       addr_i = '0;
  logic             wr_en_i = 1'b0, rd_en_i = 1'b0, rxd_i = 1'b1;
  logic [DIV_W-1:0] wdata_i = '0, rdata_o;
  logic             txd_o, tx_irq_o, rx_irq_o, ovr_irq_o;

  int n_vec = 0, n_err = 0, bdiv = 16;

  always #4 clk_i = ~clk_i;

  uart_mm u_uart_mm (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [DIV_W-1:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, input logic pop, output logic [31:0] d);
    @(negedge clk_i); addr_i = a; rd_en_i = pop;
    #1 d = 32'(rdata_o);
    @(negedge clk_i); rd_en_i = 1'b0;
  endtask

  task automatic tx_capture(output logic [7:0] b, output logic ok);
    int t = 0;
    logic s0, sp;
    b = '0;
    while (txd_o !== 1'b0 && t < 4000) begin @(negedge clk_i); t++; end
    repeat (bdiv / 2) @(negedge clk_i);
    s0 = txd_o;
    for (int i = 0; i < 8; i++) begin repeat (bdiv) @(negedge clk_i); b[i] = txd_o; end
    repeat (bdiv) @(negedge clk_i);
    sp = txd_o;
    ok = (t < 4000) && (s0 == 1'b0) && (sp == 1'b1);
    repeat (bdiv) @(negedge clk_i);
  endtask

  task automatic rx_send(input logic [7:0] b, input logic stop);
    @(negedge clk_i); rxd_i = 1'b0;
    repeat (bdiv) @(negedge clk_i);
    for (int i = 0; i < 8; i++) begin rxd_i = b[i]; repeat (bdiv) @(negedge clk_i); end
    rxd_i = stop; repeat (bdiv) @(negedge clk_i);
    rxd_i = 1'b1; repeat (bdiv) @(negedge clk_i);
  endtask

  task automatic low_len(output int n);
    int t = 0;
    n = 0;
    while (txd_o !== 1'b0 && t < 4000) begin @(negedge clk_i); t++; end
    while (txd_o === 1'b0 && n < 4000) begin n++; @(negedge clk_i); end
    repeat (bdiv * 2) @(negedge clk_i);
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  b;
    logic        ok;
    int          n;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    bus_rd(A_STATE, 1'b0, d); chk("R1 state", d, 0);
    bus_rd(A_CTRL, 1'b0, d);  chk("R1 ctrl", d, 0);
    bus_rd(A_INT, 1'b0, d);   chk("R1 int", d, 0);
    bus_rd(A_BAUD, 1'b0, d);  chk("R1 baud", d, 16);
    chk("R1 pins", {txd_o, tx_irq_o, rx_irq_o, ovr_irq_o}, 4'b1000);

    // R12 control readback
    bus_wr(A_CTRL, 21'h2A); bus_rd(A_CTRL, 1'b0, d); chk("R12 ctrl", d, 32'h2A);
    bus_wr(A_CTRL, 21'h0F); bus_rd(A_CTRL, 1'b0, d); chk("R12 ctrl", d, 32'h0F);

    foreach (VEC[k]) begin
      if (!VEC[k][8]) begin
        bus_wr(A_DATA, 21'(VEC[k][7:0]));
        tx_capture(b, ok);
        chk("R2 frame", {ok, b}, {1'b1, VEC[k][7:0]});
        bus_rd(A_INT, 1'b0, d); chk("R3 tx flag", d, 1);
        chk("R10 tx irq", tx_irq_o, 1);
        bus_wr(A_INT, 21'h1);
        chk("R9 tx flag clear", tx_irq_o, 0);
      end else begin
        rx_send(VEC[k][7:0], 1'b1);
        bus_rd(A_STATE, 1'b0, d); chk("R5 rx full", d, 2);
        chk("R10 rx irq", rx_irq_o, 1);
        bus_rd(A_DATA, 1'b1, d);  chk("R5 rx data", d, 32'(VEC[k][7:0]));
        bus_rd(A_STATE, 1'b0, d); chk("R5 rx empty", d, 0);
        bus_wr(A_INT, 21'h2);
        chk("R9 rx flag clear", rx_irq_o, 0);
      end
    end

    // R4 transmit overrun with transmitter halted
    bus_wr(A_CTRL, 21'h10);
    bus_wr(A_DATA, 21'hA5);
    bus_rd(A_STATE, 1'b0, d); chk("R3 tx full", d, 1);
    bus_wr(A_DATA, 21'h3C);
    bus_rd(A_STATE, 1'b0, d); chk("R4 tx ovr state", d, 5);
    bus_rd(A_INT, 1'b0, d);   chk("R4 tx ovr flag", d, 4);
    chk("R10 ovr irq", ovr_irq_o, 1);
    chk("R2 line idle while off", txd_o, 1);
    bus_wr(A_CTRL, 21'h01);
    chk("R10 ovr masked", ovr_irq_o, 0);
    tx_capture(b, ok);
    chk("R4 held byte sent", {ok, b}, 9'h1A5);
    bus_wr(A_INT, 21'h5);
    bus_rd(A_INT, 1'b0, d); chk("R9 int w1c", d, 0);
    bus_wr(A_STATE, 21'h4);
    bus_rd(A_STATE, 1'b0, d); chk("R9 state w1c", d, 0);

    // R6 receive overrun
    bus_wr(A_CTRL, 21'h22);
    rx_send(8'h11, 1'b1);
    rx_send(8'h22, 1'b1);
    bus_rd(A_STATE, 1'b0, d); chk("R6 rx ovr state", d, 32'hA);
    bus_rd(A_INT, 1'b0, d);   chk("R6 rx ovr flag", d, 32'hA);
    chk("R10 ovr irq rx", ovr_irq_o, 1);
    bus_rd(A_DATA, 1'b1, d);  chk("R6 kept data", d, 32'h11);
    bus_wr(A_INT, 21'h8);
    bus_rd(A_INT, 1'b0, d);   chk("R9 partial clear", d, 32'h2);
    bus_wr(A_INT, 21'h2);
    bus_wr(A_STATE, 21'h8);
    bus_rd(A_STATE, 1'b0, d); chk("R9 rx ovr clear", d, 0);

    // R7 framing error
    rx_send(8'h55, 1'b0);
    bus_rd(A_STATE, 1'b0, d); chk("R7 frame drop state", d, 0);
    bus_rd(A_INT, 1'b0, d);   chk("R7 frame drop flag", d, 0);

    // R8 receiver disabled
    bus_wr(A_CTRL, 21'h0);
    rx_send(8'h77, 1'b1);
    bus_rd(A_STATE, 1'b0, d); chk("R8 rx off", d, 0);
    bus_rd(A_INT, 1'b0, d);   chk("R8 rx off flag", d, 0);

    // R11 divisor clamp and length (0x00: start + 8 zeros = 9 bits low)
    bus_wr(A_CTRL, 21'h1);
    bus_wr(A_BAUD, 21'h4);
    bus_rd(A_BAUD, 1'b0, d); chk("R11 baud read", d, 4);
    bus_wr(A_DATA, 21'h0);
    low_len(n); chk("R11 clamp length", n, 144);
    bus_wr(A_BAUD, 21'd20); bdiv = 20;
    bus_wr(A_DATA, 21'h0);
    low_len(n); chk("R11 div20 length", n, 180);
    bus_wr(A_DATA, 21'hC3);
    tx_capture(b, ok);
    chk("R2 frame div20", {ok, b}, 9'h1C3);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule